// File: doc/BRIEF.md
# Host interrupt request generator

This block raises the host-side interrupt request lines of a keyboard-controller-style host interface: IRQ1, IRQ12, SMI, IRQ6, IRQ9, IRQ10 and IRQ11. The local CPU reaches it over a single-cycle register bus. Over that bus it writes and reads three output data registers and one byte of a two-way data register. It also sets and clears the enable bits behind each request. The host side supplies one read strobe per data register.

Every enable bit is a small state machine. It has three states:
- `EN_IDLE`: the bit reads 0 and is not armed.
- `EN_ARMED`: the bit reads 0 and a CPU read of 0 has been seen.
- `EN_SET`: the bit reads 1.

The transitions are:
- **arm** (`EN_IDLE`→`EN_ARMED`): a CPU read of the enable register. In data-linked mode the linked data register must also have been written since the last host read of it.
- **fire** (`EN_ARMED`→`EN_SET`): a CPU write of 1 to the bit, under the same data condition.
- **drop** (`EN_ARMED`→`EN_IDLE`): any other CPU write to the enable register, or a host clear.
- **clear** (`EN_SET`→`EN_IDLE`): a CPU write of 0 to the bit, or a host clear.

A host clear is a host read of the linked data register while the bit is in data-linked mode. IRQ1 and IRQ12 are always data-linked. The other enables are data-linked when `mode_cpu` is 0 and fully CPU-controlled when it is 1.

Each data register also carries a "written since last host read" flag. A CPU write sets the flag and a host read clears it. If both happen in the same cycle, the write wins.

Top module: `hirq_gen`

## Requirements
- R1: After reset, all seven request outputs are 0 and every address reads back 0.
- R2: A request in data-linked mode sets only after this sequence: a CPU write to the linked data register, then a CPU read of its enable register returning 0, then a CPU write of 1 to the bit. IRQ1 and IRQ12 follow this rule whatever the value of `mode_cpu`.
- R3: A CPU write of 1 is ignored unless the bit was armed by an earlier read of 0. Any CPU write to the enable register consumes the arm.
- R4: In data-linked mode, a read of 0 arms the bit only if the linked data register has been written since the last host read of it. A write of 1 sets the bit only under the same condition.
- R5: A data-linked request clears on a CPU write of 0 to its bit, or on a host read of the linked data register. A host read in the same cycle as a write of 1 leaves the request clear.
- R6: With `mode_cpu`=1, SMI and IRQ6/9/10/11 enables set on a read of 0 followed by a write of 1, with no data write needed. Only a CPU write of 0 clears them; host reads do not affect them.
- R7: SMI is the OR of its three sources. Each of IRQ6, IRQ9, IRQ10 and IRQ11 is the OR of its two sources.
- R8: The register map is as follows:
  - Addresses 0 to 3 hold data registers D0 to D3: output data 1, 2 and 3, then the two-way byte. Each reads back its last written value.
  - Address 4 is enable register E0, linked to D0: bit0 IRQ1, bit1 IRQ12.
  - Address 5 is E1, linked to D1: bit0 SMI source A, bits 1 to 4 for IRQ6, IRQ9, IRQ10 and IRQ11.
  - Address 6 is E2, linked to D2, with the same layout as E1 but with SMI source B in bit0.
  - Address 7 is E3, linked to D3: bit0 SMI source C.
  - Unused enable bits read 0.
  - `host_rd[i]` is the host read strobe for Di.
- R9: A CPU write and a host read of the same data register in the same cycle leave that register marked as written.
- R10: Outputs change only at a clock edge after a CPU write or a host read strobe. A CPU read alone leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle |
| cpu_re | input | 1 | CPU read strobe, one cycle |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data, combinational from address |
| host_rd | input | 4 | Host read strobes for D0..D3 |
| mode_cpu | input | 1 | 1 selects CPU-controlled mode for SMI and IRQ6/9-11 |
| irq1 | output | 1 | IRQ1 request |
| irq12 | output | 1 | IRQ12 request |
| smi | output | 1 | SMI request |
| irq6 | output | 1 | IRQ6 request |
| irq9 | output | 1 | IRQ9 request |
| irq10 | output | 1 | IRQ10 request |
| irq11 | output | 1 | IRQ11 request |

## Verification
The assertions take for granted that the CPU never raises `cpu_we` and `cpu_re` in the same cycle, and that `mode_cpu` only matters at the clock edge where a transition is decided. The stimulus picks one CPU operation, or none, per cycle, so the two strobes are never both high. It flips `mode_cpu` only between long random runs. Host strobes are drawn sparsely and independently per register. This lets them collide with CPU writes and with enable writes of 1, which exercises the priority rules.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    localparam int NUM_REG = 4;
    localparam int MAX_EN  = 5;

    typedef enum logic [1:0] {
        EN_IDLE  = 2'd0,
        EN_ARMED = 2'd1,
        EN_SET   = 2'd2
    } en_state_t;

    // number of enable bits held by enable register r
    function automatic int en_count(input int r);
        case (r)
            0:       return 2;
            3:       return 1;
            default: return MAX_EN;
        endcase
    endfunction

endpackage

// File: rtl/hirq_en_cell.sv
module hirq_en_cell
    import hirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic linked,
    input  logic fresh,
    input  logic host_clr,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic en_o
);

    en_state_t st_q, st_d;
    logic      may_set;

    assign may_set = !linked || fresh;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EN_IDLE: begin
                if (rd_hit && may_set && !host_clr) st_d = EN_ARMED;
            end
            EN_ARMED: begin
                if (host_clr)    st_d = EN_IDLE;
                else if (wr_hit) st_d = (wr_bit && may_set) ? EN_SET : EN_IDLE;
            end
            EN_SET: begin
                if (host_clr || (wr_hit && !wr_bit)) st_d = EN_IDLE;
            end
            default: st_d = EN_IDLE;
        endcase
    end

    always_comb begin
        en_o = (st_q == EN_SET);
    end

endmodule

// File: rtl/hirq_data_bank.sv
module hirq_data_bank #(
    parameter int NREG   = 4,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NREG-1:0]             wr_sel,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NREG-1:0]             host_rd,
    output logic [NREG-1:0][DATA_W-1:0] data_o,
    output logic [NREG-1:0]             fresh_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_o[i]  <= '0;
                fresh_o[i] <= 1'b0;
            end else if (wr_sel[i]) begin
                data_o[i]  <= wdata;
                fresh_o[i] <= 1'b1;
            end else if (host_rd[i]) begin
                fresh_o[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hirq_merge.sv
module hirq_merge #(
    parameter int MAX_EN = 5
) (
    input  logic [1:0]        src0,
    input  logic [MAX_EN-1:0] src1,
    input  logic [MAX_EN-1:0] src2,
    input  logic              src3,
    output logic              irq1,
    output logic              irq12,
    output logic              smi,
    output logic [3:0]        irqx
);

    assign irq1  = src0[0];
    assign irq12 = src0[1];
    assign smi   = src1[0] | src2[0] | src3;

    for (genvar k = 0; k < 4; k++) begin : g_or
        assign irqx[k] = src1[k+1] | src2[k+1];
    end

endmodule

// File: rtl/hirq_gen.sv
module hirq_gen
    import hirq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [3:0]        host_rd,
    input  logic              mode_cpu,
    output logic              irq1,
    output logic              irq12,
    output logic              smi,
    output logic              irq6,
    output logic              irq9,
    output logic              irq10,
    output logic              irq11
);

    localparam int EN_BASE = NUM_REG;

    logic [NUM_REG-1:0]             data_wr;
    logic [NUM_REG-1:0][DATA_W-1:0] data_q;
    logic [NUM_REG-1:0]             fresh_q;
    logic [NUM_REG-1:0][MAX_EN-1:0] en_q;
    logic [3:0]                     irqx;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_dec
        assign data_wr[r] = cpu_we && (cpu_addr == ADDR_W'(r));
    end

    hirq_data_bank #(.NREG(NUM_REG), .DATA_W(DATA_W)) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (data_wr),
        .wdata  (cpu_wdata),
        .host_rd(host_rd),
        .data_o (data_q),
        .fresh_o(fresh_q)
    );

    for (genvar r = 0; r < NUM_REG; r++) begin : g_ereg
        logic rd_hit, wr_hit, linked;
        assign rd_hit = cpu_re && (cpu_addr == ADDR_W'(EN_BASE + r));
        assign wr_hit = cpu_we && (cpu_addr == ADDR_W'(EN_BASE + r));
        // register 0 carries IRQ1/IRQ12, which stay data-linked in both modes
        assign linked = (r == 0) || !mode_cpu;
        for (genvar b = 0; b < MAX_EN; b++) begin : g_bit
            if (b < en_count(r)) begin : g_cell
                hirq_en_cell cell_i (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .linked  (linked),
                    .fresh   (fresh_q[r]),
                    .host_clr(host_rd[r] && linked),
                    .rd_hit  (rd_hit),
                    .wr_hit  (wr_hit),
                    .wr_bit  (cpu_wdata[b]),
                    .en_o    (en_q[r][b])
                );
            end else begin : g_none
                assign en_q[r][b] = 1'b0;
            end
        end
    end

    always_comb begin
        cpu_rdata = '0;
        for (int r = 0; r < NUM_REG; r++) begin
            if (cpu_addr == ADDR_W'(r))           cpu_rdata = data_q[r];
            if (cpu_addr == ADDR_W'(EN_BASE + r)) cpu_rdata = DATA_W'(en_q[r]);
        end
    end

    hirq_merge #(.MAX_EN(MAX_EN)) merge_i (
        .src0 (en_q[0][1:0]),
        .src1 (en_q[1]),
        .src2 (en_q[2]),
        .src3 (en_q[3][0]),
        .irq1 (irq1),
        .irq12(irq12),
        .smi  (smi),
        .irqx (irqx)
    );

    assign irq6  = irqx[0];
    assign irq9  = irqx[1];
    assign irq10 = irqx[2];
    assign irq11 = irqx[3];

endmodule

// File: rtl/hirq_gen_chk.sv
module hirq_gen_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_we,
    input logic              cpu_re,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [3:0]        host_rd,
    input logic              mode_cpu,
    input logic              irq1,
    input logic              irq12,
    input logic              smi,
    input logic              irq6,
    input logic              irq9,
    input logic              irq10,
    input logic              irq11
);

    logic [6:0] lines;
    assign lines = {irq1, irq12, smi, irq6, irq9, irq10, irq11};

    // R3: IRQ1 only rises after a CPU write of 1 to its enable bit
    a_r3_irq1_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq1) |-> $past(cpu_we && cpu_addr == ADDR_W'(4) && cpu_wdata[0]));

    // R5: a CPU write of 0 clears IRQ1
    a_r5_write0_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == ADDR_W'(4) && !cpu_wdata[0]) |=> !irq1);

    // R5: a host read of D0 clears both linked requests, even against a write of 1
    a_r5_host_clear: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd[0] |=> (!irq1 && !irq12));

    // R6: in CPU-controlled mode SMI falls only after a CPU write
    a_r6_smi_cpu_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cpu && !cpu_we) |=> !$fell(smi));

    // R10: a CPU read with no host strobe leaves all requests unchanged
    a_r10_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && !cpu_we && host_rd == 4'b0) |=> $stable(lines));

endmodule

bind hirq_gen hirq_gen_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .host_rd(host_rd),
    .mode_cpu(mode_cpu), .irq1(irq1), .irq12(irq12), .smi(smi),
    .irq6(irq6), .irq9(irq9), .irq10(irq10), .irq11(irq11)
);

// File: tb/hirq_gen_tb_top.sv
`timescale 1ns/1ps
module hirq_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0, cpu_re = 1'b0, mode_cpu = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [3:0] host_rd = '0;
    logic       irq1, irq12, smi, irq6, irq9, irq10, irq11;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hirq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .host_rd(host_rd), .mode_cpu(mode_cpu), .irq1(irq1), .irq12(irq12),
        .smi(smi), .irq6(irq6), .irq9(irq9), .irq10(irq10), .irq11(irq11)
    );

    // reference model state
    bit       en_m  [4][5];
    bit       arm_m [4][5];
    bit       fresh_m [4];
    bit [7:0] data_m [4];

    function automatic int nbits(int r);
        return (r == 0) ? 2 : (r == 3) ? 1 : 5;
    endfunction

    function automatic bit [7:0] model_rdata(bit [2:0] a);
        bit [7:0] v = '0;
        if (a < 4) v = data_m[a];
        else for (int b = 0; b < 5; b++) v[b] = en_m[a-4][b];
        return v;
    endfunction

    function automatic bit [6:0] model_lines();
        bit [6:0] v;
        v[6] = en_m[0][0];
        v[5] = en_m[0][1];
        v[4] = en_m[1][0] | en_m[2][0] | en_m[3][0];
        for (int k = 0; k < 4; k++) v[3-k] = en_m[1][k+1] | en_m[2][k+1];
        return v;
    endfunction

    task automatic model_step(bit we, bit re, bit [2:0] a, bit [7:0] wd, bit [3:0] hr);
        for (int r = 0; r < 4; r++) begin
            bit linked = (r == 0) || !mode_cpu;
            bit hclr = linked && hr[r];
            bit may = !linked || fresh_m[r];
            bit rd = re && (a == 3'(4 + r));
            bit wr = we && (a == 3'(4 + r));
            for (int b = 0; b < nbits(r); b++) begin
                if (en_m[r][b]) begin
                    if (hclr || (wr && !wd[b])) en_m[r][b] = 0;
                end else if (arm_m[r][b]) begin
                    if (hclr) arm_m[r][b] = 0;
                    else if (wr) begin
                        arm_m[r][b] = 0;
                        en_m[r][b] = wd[b] && may;
                    end
                end else if (rd && may && !hclr) begin
                    arm_m[r][b] = 1;
                end
            end
        end
        for (int r = 0; r < 4; r++) begin
            if (we && a == 3'(r)) begin
                fresh_m[r] = 1;
                data_m[r] = wd;
            end else if (hr[r]) fresh_m[r] = 0;
        end
    endtask

    task automatic check(bit ok, string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one bus cycle, driven at the falling edge, outputs sampled after the rising edge
    task automatic step(bit we, bit re, bit [2:0] a, bit [7:0] wd, bit [3:0] hr, string tag);
        bit [7:0] er;
        bit [6:0] el;
        cpu_we = we; cpu_re = re; cpu_addr = a; cpu_wdata = wd; host_rd = hr;
        #2;
        if (re) begin
            er = model_rdata(a);
            check(cpu_rdata === er, tag, cpu_rdata, er);
        end
        model_step(we, re, a, wd, hr);
        @(posedge clk);
        #3;
        el = model_lines();
        check({irq1, irq12, smi, irq6, irq9, irq10, irq11} === el, tag,
              {1'b0, irq1, irq12, smi, irq6, irq9, irq10, irq11}, {1'b0, el});
        @(negedge clk);
    endtask

    task automatic wr(bit [2:0] a, bit [7:0] d, string tag);
        step(1, 0, a, d, 4'b0, tag);
    endtask
    task automatic rd(bit [2:0] a, string tag);
        step(0, 1, a, 8'h00, 4'b0, tag);
    endtask
    task automatic hrd(bit [3:0] h, string tag);
        step(0, 0, 3'd0, 8'h00, h, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 8; a++) rd(3'(a), "R1");
        check({irq1, irq12, smi, irq6, irq9, irq10, irq11} == 7'b0, "R1", {1'b0, irq1, irq12, smi, irq6, irq9, irq10, irq11}, 8'h00);

        // R4: read before any data write does not arm; write 1 ignored
        rd(3'd4, "R4");
        wr(3'd4, 8'h01, "R4");
        check(irq1 == 1'b0, "R4", {7'b0, irq1}, 8'h00);

        // R2: data write, read 0, write 1 sets IRQ1
        wr(3'd0, 8'hA5, "R2");
        rd(3'd4, "R2");
        wr(3'd4, 8'h01, "R2");
        check(irq1 == 1'b1, "R2", {7'b0, irq1}, 8'h01);

        // R3: write 1 to IRQ12 without an armed read is ignored; arm consumed by another write
        wr(3'd4, 8'h03, "R3");
        check(irq12 == 1'b0, "R3", {7'b0, irq12}, 8'h00);
        rd(3'd4, "R3");
        wr(3'd4, 8'h01, "R3");
        wr(3'd4, 8'h03, "R3");
        check(irq12 == 1'b0, "R3", {7'b0, irq12}, 8'h00);

        // R5: host read of D0 clears IRQ1
        hrd(4'b0001, "R5");
        check(irq1 == 1'b0, "R5", {7'b0, irq1}, 8'h00);
        // R5: CPU write 0 clears
        wr(3'd0, 8'h11, "R5"); rd(3'd4, "R5"); wr(3'd4, 8'h01, "R5");
        wr(3'd4, 8'h00, "R5");
        check(irq1 == 1'b0, "R5", {7'b0, irq1}, 8'h00);
        // R5: host read in the same cycle as the write of 1 wins
        wr(3'd0, 8'h22, "R5"); rd(3'd4, "R5");
        step(1, 0, 3'd4, 8'h01, 4'b0001, "R5");
        check(irq1 == 1'b0, "R5", {7'b0, irq1}, 8'h00);

        // R9: write and host read of D0 together leave it marked as written
        step(1, 0, 3'd0, 8'h33, 4'b0001, "R9");
        rd(3'd4, "R9"); wr(3'd4, 8'h02, "R9");
        check(irq12 == 1'b1, "R9", {7'b0, irq12}, 8'h01);

        // R8: data registers read back
        wr(3'd1, 8'h5A, "R8"); rd(3'd1, "R8");
        wr(3'd3, 8'hC3, "R8"); rd(3'd3, "R8");

        // R6: CPU-controlled mode, no data write needed, host reads ignored
        mode_cpu = 1'b1;
        hrd(4'b1111, "R6");
        rd(3'd6, "R6"); wr(3'd6, 8'h01, "R6");
        check(smi == 1'b1, "R6", {7'b0, smi}, 8'h01);
        hrd(4'b0100, "R6");
        check(smi == 1'b1, "R6", {7'b0, smi}, 8'h01);
        // R2: IRQ12 stays data-linked in CPU mode
        hrd(4'b0001, "R2");
        rd(3'd4, "R2"); wr(3'd4, 8'h02, "R2");
        check(irq12 == 1'b0, "R2", {7'b0, irq12}, 8'h00);

        // R7: OR of sources
        rd(3'd7, "R7"); wr(3'd7, 8'h01, "R7");
        wr(3'd6, 8'h00, "R7");
        check(smi == 1'b1, "R7", {7'b0, smi}, 8'h01);
        rd(3'd5, "R7"); wr(3'd5, 8'h04, "R7");
        rd(3'd6, "R7"); wr(3'd6, 8'h04, "R7");
        wr(3'd5, 8'h00, "R7");
        check(irq9 == 1'b1, "R7", {7'b0, irq9}, 8'h01);
        rd(3'd5, "R8");

        // random phases, model-checked
        for (int ph = 0; ph < 4; ph++) begin
            mode_cpu = ph[0];
            for (int i = 0; i < 1500; i++) begin
                int op = $urandom_range(0, 9);
                bit [2:0] a = 3'($urandom_range(0, 7));
                bit [7:0] d = 8'($urandom);
                bit [3:0] h = '0;
                for (int k = 0; k < 4; k++) h[k] = ($urandom_range(0, 9) == 0);
                if (op < 4)      step(1, 0, a, d, h, "R7");
                else if (op < 8) step(0, 1, a, 8'h00, h, "R10");
                else             step(0, 0, a, 8'h00, h, "R6");
            end
        end
        step(0, 0, 3'd0, 8'h00, 4'b0, "R10");
        finish_run();
    end

endmodule